// File: doc/BRIEF.md
# AHB-lite burst progress tracker

This block watches the address-phase control signals of an AHB-lite slave port and follows each burst from its first transfer to its end. It keeps a running beat number and the beats still owed for fixed-length bursts. It emits one-cycle event pulses when a burst completes, when a burst is cut short, when a cut-short burst last showed a stall, and when a transfer type arrives that makes no sense outside a burst. A saturating counter records how often bursts were cut short.

A prefetching slave uses these outputs to decide when buffered read data is still wanted and when it must be thrown away. A verification environment can use the same outputs as a passive protocol observer. Only the transfer type, burst type, select and ready inputs are looked at. Addresses, write data and responses are not examined.

Top module: `ahb_burst_tracker`

## Requirements
- R1: While `rst_ni` is low, every output is zero: `active_o`, `beat_cnt_o`, `beats_left_o`, all pulses, and `term_cnt_o`.
- R2: A transfer is sampled only on a rising edge with `ready_i` high. It is read as IDLE when `sel_i` is low. Transfer codes are IDLE=0, BUSY=1, NONSEQ=2, SEQ=3. A sampled NONSEQ with a fixed-length burst code starts a burst: `active_o`=1, `beat_cnt_o`=1, and `beats_left_o` = length−1. The burst codes 2/3 give length 4, 4/5 give length 8, and 6/7 give length 16.
- R3: Each sampled SEQ in an active burst adds one to `beat_cnt_o`. In a fixed-length burst it also subtracts one from `beats_left_o`. The SEQ that takes `beats_left_o` to 0 raises `done_o` for one cycle and clears `active_o`.
- R4: A sampled BUSY inside an active burst leaves `beat_cnt_o`, `beats_left_o` and `active_o` unchanged.
- R5: A sampled IDLE or NONSEQ while a fixed-length burst still owes beats raises `early_term_o` for one cycle and clears `beats_left_o`. A NONSEQ at that edge also starts the next burst.
- R6: If the last sampled transfer of such a cut-short burst was BUSY, `busy_end_o` is raised together with `early_term_o`.
- R7: Burst code 1 (undefined length) starts a burst with `beats_left_o`=0. A later IDLE or NONSEQ ends that burst without `early_term_o`.
- R8: A sampled SEQ or BUSY while no burst is active raises `viol_o` for one cycle and leaves the counts unchanged.
- R9: With `ready_i` low, nothing is sampled. The counts and `active_o` hold, and no pulse is raised.
- R10: `term_cnt_o` increases by one in the cycle after each `early_term_o` pulse. It holds at its all-ones value and returns to 0 on reset.
- R11: Burst code 0 (single transfer) with NONSEQ sets `beat_cnt_o`=1 and leaves `active_o`=0. It raises no `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Slave selected |
| ready_i | input | 1 | Bus ready; qualifies sampling |
| trans_i | input | 2 | Transfer type |
| burst_i | input | 3 | Burst type |
| active_o | output | 1 | A burst is in progress |
| beat_cnt_o | output | BEAT_W | Beats accepted in the current or most recent burst |
| beats_left_o | output | BEAT_W | Beats still owed by a fixed-length burst |
| done_o | output | 1 | Pulse: fixed-length burst completed |
| early_term_o | output | 1 | Pulse: fixed-length burst cut short |
| busy_end_o | output | 1 | Pulse: cut-short burst last showed BUSY |
| viol_o | output | 1 | Pulse: SEQ or BUSY outside a burst |
| term_cnt_o | output | TERM_W | Saturating count of early terminations |

## Verification
On every cycle, the assertions check the following:
- BUSY never advances the counts, and a stalled bus changes nothing.
- A stray SEQ or BUSY is always flagged.
- A completion pulse never coincides with an open burst or a termination.
- The BUSY-ending flag is always a subset of early termination.
- The termination counter steps once per event and sticks at its ceiling.

Only the bench's scenarios can show the exact beat arithmetic of each burst length, that the right burst is ended when one burst is cut short by the next, that undefined-length bursts end quietly, and that the counter saturates at the real ceiling.

// File: rtl/ahb_trk_pkg.sv
package ahb_trk_pkg;
  typedef enum logic [1:0] {
    TR_IDLE = 2'd0,
    TR_BUSY = 2'd1,
    TR_NSEQ = 2'd2,
    TR_SEQ  = 2'd3
  } trans_e;

  localparam int unsigned LEN_W = 5;

  // Fixed length from burst code; 0 means undefined length or single.
  function automatic logic [LEN_W-1:0] burst_len(input logic [2:0] code);
    case (code[2:1])
      2'd1:    burst_len = LEN_W'(4);
      2'd2:    burst_len = LEN_W'(8);
      2'd3:    burst_len = LEN_W'(16);
      default: burst_len = '0;
    endcase
  endfunction
endpackage

// File: rtl/ahb_trk_decode.sv
module ahb_trk_decode
  import ahb_trk_pkg::*;
(
  input  logic             sel_i,
  input  logic             ready_i,
  input  logic [1:0]       trans_i,
  input  logic [2:0]       burst_i,
  output logic             acc_o,
  output trans_e           eff_o,
  output logic [LEN_W-1:0] len_o,
  output logic             undef_o,
  output logic             single_o
);
  assign acc_o    = ready_i;
  assign eff_o    = sel_i ? trans_e'(trans_i) : TR_IDLE;
  assign len_o    = burst_len(burst_i);
  assign undef_o  = (burst_i == 3'd1);
  assign single_o = (burst_i == 3'd0);
endmodule

// File: rtl/ahb_trk_ctl.sv
module ahb_trk_ctl
  import ahb_trk_pkg::*;
#(
  parameter int unsigned BEAT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  trans_e            eff_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              undef_i,
  input  logic              single_i,
  output logic              active_o,
  output logic [BEAT_W-1:0] beat_cnt_o,
  output logic [BEAT_W-1:0] beats_left_o,
  output logic              done_o,
  output logic              early_o,
  output logic              busy_end_o,
  output logic              viol_o
);
  localparam logic [BEAT_W-1:0] BEAT_MAX = '1;

  logic              act_q, act_n, und_q, und_n, lb_q, lb_n;
  logic [BEAT_W-1:0] beat_q, beat_n, left_q, left_n;
  logic              dn_n, et_n, be_n, vi_n;

  always_comb begin
    act_n  = act_q;
    und_n  = und_q;
    lb_n   = lb_q;
    beat_n = beat_q;
    left_n = left_q;
    dn_n   = 1'b0;
    et_n   = 1'b0;
    be_n   = 1'b0;
    vi_n   = 1'b0;
    if (acc_i) begin
      unique case (eff_i)
        TR_IDLE, TR_NSEQ: begin
          if (act_q && !und_q && left_q != '0) begin
            et_n = 1'b1;
            be_n = lb_q;
          end
          act_n  = 1'b0;
          left_n = '0;
          lb_n   = 1'b0;
          if (eff_i == TR_NSEQ) begin
            beat_n = BEAT_W'(1);
            und_n  = undef_i;
            if (!single_i) begin
              act_n  = 1'b1;
              left_n = undef_i ? '0 : BEAT_W'(len_i - 1'b1);
            end
          end
        end
        TR_SEQ: begin
          if (!act_q) vi_n = 1'b1;
          else begin
            lb_n = 1'b0;
            if (beat_q != BEAT_MAX) beat_n = beat_q + 1'b1;
            if (!und_q) begin
              left_n = left_q - 1'b1;
              if (left_q == BEAT_W'(1)) begin
                dn_n  = 1'b1;
                act_n = 1'b0;
              end
            end
          end
        end
        default: begin // BUSY: stall only
          if (!act_q) vi_n = 1'b1;
          else lb_n = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      und_q      <= 1'b0;
      lb_q       <= 1'b0;
      beat_q     <= '0;
      left_q     <= '0;
      done_o     <= 1'b0;
      early_o    <= 1'b0;
      busy_end_o <= 1'b0;
      viol_o     <= 1'b0;
    end else begin
      act_q      <= act_n;
      und_q      <= und_n;
      lb_q       <= lb_n;
      beat_q     <= beat_n;
      left_q     <= left_n;
      done_o     <= dn_n;
      early_o    <= et_n;
      busy_end_o <= be_n;
      viol_o     <= vi_n;
    end
  end

  assign active_o     = act_q;
  assign beat_cnt_o   = beat_q;
  assign beats_left_o = left_q;
endmodule

// File: rtl/ahb_trk_satcnt.sv
module ahb_trk_satcnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_o <= '0;
    else if (inc_i && ~&cnt_o)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ahb_burst_tracker.sv
module ahb_burst_tracker
  import ahb_trk_pkg::*;
#(
  parameter int unsigned BEAT_W = 5,
  parameter int unsigned TERM_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              ready_i,
  input  logic [1:0]        trans_i,
  input  logic [2:0]        burst_i,
  output logic              active_o,
  output logic [BEAT_W-1:0] beat_cnt_o,
  output logic [BEAT_W-1:0] beats_left_o,
  output logic              done_o,
  output logic              early_term_o,
  output logic              busy_end_o,
  output logic              viol_o,
  output logic [TERM_W-1:0] term_cnt_o
);
  logic             acc, undef, single;
  trans_e           eff;
  logic [LEN_W-1:0] len;

  ahb_trk_decode u_dec (
    .sel_i, .ready_i, .trans_i, .burst_i,
    .acc_o(acc), .eff_o(eff), .len_o(len), .undef_o(undef), .single_o(single)
  );

  ahb_trk_ctl #(.BEAT_W(BEAT_W)) u_ctl (
    .clk_i, .rst_ni,
    .acc_i(acc), .eff_i(eff), .len_i(len), .undef_i(undef), .single_i(single),
    .active_o, .beat_cnt_o, .beats_left_o,
    .done_o, .early_o(early_term_o), .busy_end_o, .viol_o
  );

  ahb_trk_satcnt #(.W(TERM_W)) u_cnt (
    .clk_i, .rst_ni, .inc_i(early_term_o), .cnt_o(term_cnt_o)
  );
endmodule

// File: rtl/ahb_burst_tracker_chk.sv
module ahb_burst_tracker_chk #(
  parameter int unsigned BEAT_W = 5,
  parameter int unsigned TERM_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              ready_i,
  input logic [1:0]        trans_i,
  input logic [2:0]        burst_i,
  input logic              active_o,
  input logic [BEAT_W-1:0] beat_cnt_o,
  input logic [BEAT_W-1:0] beats_left_o,
  input logic              done_o,
  input logic              early_term_o,
  input logic              busy_end_o,
  input logic              viol_o,
  input logic [TERM_W-1:0] term_cnt_o
);
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> $stable(beat_cnt_o) && $stable(beats_left_o) && $stable(active_o)
                 && !done_o && !early_term_o && !viol_o); // R9
  AST_BUSY_NO_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && sel_i && trans_i == 2'd1 && active_o
      |=> $stable(beat_cnt_o) && $stable(beats_left_o) && active_o); // R4
  AST_STRAY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && sel_i && trans_i[0] && !active_o |=> viol_o); // R8
  AST_DONE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !active_o && beats_left_o == '0 && !early_term_o); // R3
  AST_BUSY_END_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_end_o |-> early_term_o); // R6
  AST_UNDEF_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && sel_i && trans_i == 2'd2 && burst_i == 3'd1
      |=> active_o && beats_left_o == '0 && beat_cnt_o == BEAT_W'(1)); // R7
  AST_TERM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_term_o && term_cnt_o != '1 |=> term_cnt_o == $past(term_cnt_o) + 1'b1); // R10
  AST_TERM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !early_term_o |=> $stable(term_cnt_o)); // R10
  AST_TERM_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_cnt_o == '1 |=> term_cnt_o == '1); // R10
endmodule

bind ahb_burst_tracker ahb_burst_tracker_chk #(.BEAT_W(BEAT_W), .TERM_W(TERM_W)) u_chk (.*);

// File: tb/ahb_burst_tracker_tb.sv
`timescale 1ns/1ps
module ahb_burst_tracker_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sel = 1'b0, rdy = 1'b0;
  logic [1:0] tr = 2'd0;
  logic [2:0] bu = 3'd0;
  logic       act, dn, et, be, vi;
  logic [4:0] beat, left;
  logic [3:0] tcnt;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  ahb_burst_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .ready_i(rdy), .trans_i(tr), .burst_i(bu),
    .active_o(act), .beat_cnt_o(beat), .beats_left_o(left), .done_o(dn),
    .early_term_o(et), .busy_end_o(be), .viol_o(vi), .term_cnt_o(tcnt)
  );

  typedef struct packed {
    logic sel; logic rdy; logic [1:0] tr; logic [2:0] bu;
    logic act; logic [4:0] beat; logic [4:0] left;
    logic dn; logic et; logic be; logic vi;
  } vec_t;

  localparam int NV = 22;
  // trans: 0 IDLE 1 BUSY 2 NONSEQ 3 SEQ; burst: 0 single 1 undef 3 len4 5 len8 7 len16
  localparam vec_t VEC [NV] = '{
    '{1,1,2,3, 1,1,3,  0,0,0,0}, // R2
    '{1,1,1,3, 1,1,3,  0,0,0,0}, // R4
    '{1,1,3,3, 1,2,2,  0,0,0,0}, // R3
    '{1,0,3,3, 1,2,2,  0,0,0,0}, // R9
    '{1,1,3,3, 1,3,1,  0,0,0,0}, // R3
    '{1,1,3,3, 0,4,0,  1,0,0,0}, // R3
    '{1,1,0,0, 0,4,0,  0,0,0,0}, // R3
    '{1,1,3,0, 0,4,0,  0,0,0,1}, // R8
    '{1,1,2,5, 1,1,7,  0,0,0,0}, // R2
    '{1,1,3,5, 1,2,6,  0,0,0,0}, // R3
    '{1,1,2,3, 1,1,3,  0,1,0,0}, // R5
    '{1,1,3,3, 1,2,2,  0,0,0,0}, // R3
    '{1,1,1,3, 1,2,2,  0,0,0,0}, // R4
    '{1,1,0,0, 0,2,0,  0,1,1,0}, // R6
    '{1,1,2,1, 1,1,0,  0,0,0,0}, // R7
    '{1,1,3,1, 1,2,0,  0,0,0,0}, // R7
    '{1,1,1,1, 1,2,0,  0,0,0,0}, // R4
    '{1,1,3,1, 1,3,0,  0,0,0,0}, // R7
    '{1,1,2,7, 1,1,15, 0,0,0,0}, // R7
    '{0,1,2,7, 0,1,0,  0,1,0,0}, // R5
    '{1,1,2,0, 0,1,0,  0,0,0,0}, // R11
    '{1,1,1,0, 0,1,0,  0,0,0,1}  // R8
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 8:            return "R2";
      2, 4, 5, 6, 9, 11: return "R3";
      1, 12, 16:       return "R4";
      10, 19:          return "R5";
      13:              return "R6";
      14, 15, 17, 18:  return "R7";
      7, 21:           return "R8";
      3:               return "R9";
      default:         return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic s, input logic r, input logic [1:0] t, input logic [2:0] b);
    sel = s; rdy = r; tr = t; bu = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] outs();
    return {13'd0, act, beat, left, dn, et, be, vi, 4'd0, 2'd0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {act, beat, left, dn, et, be, vi, tcnt}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].sel, VEC[i].rdy, VEC[i].tr, VEC[i].bu);
      check(tag_of(i), outs(),
            {13'd0, VEC[i].act, VEC[i].beat, VEC[i].left,
             VEC[i].dn, VEC[i].et, VEC[i].be, VEC[i].vi, 6'd0});
    end

    step(1'b1, 1'b0, 2'd0, 3'd0);
    check("R10 count", 32'(tcnt), 32'd3);

    // R9: stalled NONSEQ must not start a burst
    step(1'b1, 1'b0, 2'd2, 3'd3);
    check("R9 stall", {31'd0, act}, 32'd0);

    // R10: drive to saturation
    for (int k = 0; k < 14; k++) begin
      step(1'b1, 1'b1, 2'd2, 3'd3);
      step(1'b1, 1'b1, 2'd0, 3'd0);
    end
    step(1'b1, 1'b0, 2'd0, 3'd0);
    check("R10 saturate", 32'(tcnt), 32'd15);
    step(1'b1, 1'b1, 2'd2, 3'd5);
    step(1'b1, 1'b1, 2'd0, 3'd0);
    step(1'b1, 1'b0, 2'd0, 3'd0);
    check("R10 hold", 32'(tcnt), 32'd15);

    // R3: full length-16 burst completes on the sixteenth beat
    step(1'b1, 1'b1, 2'd2, 3'd6);
    for (int k = 0; k < 14; k++) step(1'b1, 1'b1, 2'd3, 3'd6);
    check("R3 len16 pre", {26'd0, act, beat}, {26'd0, 1'b1, 5'd15});
    step(1'b1, 1'b1, 2'd3, 3'd6);
    check("R3 len16 done", {25'd0, dn, act, beat}, {25'd0, 1'b1, 1'b0, 5'd16});

    // R1, R10: reset clears everything including the counter
    rst_n = 1'b0;
    #1;
    check("R1 reset", {act, beat, left, dn, et, be, vi, tcnt}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 cleared", 32'(tcnt), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule